// File: doc/BRIEF.md
# Pipelined Operand Routing Row

This block sits between two consecutive rows of processing elements in a pipelined compute array and carries results downward only. Each of the M upper-row elements presents a data word with a valid bit. Each of the M lower-row elements receives two operand lines, A and B. A source at column j can land only on lower-row columns j through j+MCL. Nothing travels sideways to the left and nothing travels back up.

Each operand port has its own fabric. Every source enters that fabric through a one-in, two-out splitter cell, which places the word on a "stay" track, a "move" track, both tracks or neither. Then come MCL hops of two-in, two-out crossbar cells, one cell per column. At each hop the move track steps one column to the right. A cell can park an arriving word on the stay track, pass it on, swap it with the word already parked there, or duplicate either input onto both outputs.

A register sits after the splitters and after every hop, and a two-deep shift register sits on the output. Every route therefore has the same latency, and operands from different sources reach a lower-row element in the same cycle. All routing codes are static configuration inputs and are changed only while the fabric carries no valid data.

Top module: `orn_row`

## Requirements
- R1: With a synchronous active-high `rst` sampled high at a clock edge, every pipeline stage clears, so after that edge all of `opa_valid`, `opb_valid`, `opa_data` and `opb_data` read zero.
- R2: Every path from a source to an operand line has a latency of exactly MCL+3 clock edges, whatever the route.
- R3: The splitter code for source j on port p (p=0 is port A, p=1 is port B) is `cfg_half[2*(p*M+j) +: 2]`. Field bit 0 enables the stay output and field bit 1 enables the move output, so 00 gives neither, 01 gives stay only, 10 gives move only and 11 gives both. A disabled output is idle.
- R4: The crossbar code for port p, hop h (1..MCL) and column c is `cfg_xbar[2*((p*MCL+h-1)*M+c) +: 2]`. Input 0 is the stay track of column c and input 1 is the move track from column c-1, which is idle at c=0. Output 0 becomes the new stay track and output 1 the new move track. The codes are 00 pass, 01 swap, 10 input 0 to both outputs, 11 input 1 to both outputs.
- R5: The operand for lower column k on port p is the stay track of column k after hop MCL. Move tracks that leave column M-1 or that remain after the last hop are discarded.
- R6: An operand at column k carries only a word that entered at a source column from k-MCL to k. A word moved and then parked at hop d lands exactly d columns to the right.
- R7: A source whose valid bit is low is idle whatever its data. An idle lane is valid 0 and data 0, so any operand line with valid low reads data zero.
- R8: One source can feed several lower columns and both ports at the same time through splitter code 11 and crossbar code 11.
- R9: Once MCL+3 consecutive edges have seen no valid source, every operand line is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_valid | input | M | Valid bit per upper-row source |
| src_data | input | M*DATA_W | Source words, column j at bits [j*DATA_W +: DATA_W] |
| cfg_half | input | 4*M | Splitter codes for both ports (R3) |
| cfg_xbar | input | 4*MCL*M | Crossbar codes for both ports (R4) |
| opa_valid | output | M | Valid bit of operand A per lower column |
| opa_data | output | M*DATA_W | Operand A words per lower column |
| opb_valid | output | M | Valid bit of operand B per lower column |
| opb_data | output | M*DATA_W | Operand B words per lower column |

## Verification
Four properties are checked on every cycle: outputs clear after a reset, an invalid operand line carries zero data, a run of idle cycles drains the fabric, and no valid operand at column k appears without a valid source inside that column's window MCL+3 edges earlier. The exact word that lands on each line cannot be expressed as a property, and neither can the meaning of each splitter and crossbar code, the equal latency of different routes, multicast, or the discarding of words at the right edge. Those are shown only by the bench's directed routings and its random configurations, which are compared against an independent cell-by-cell model.

// File: rtl/orn_pkg.sv
package orn_pkg;

    typedef enum logic [1:0] {
        XB_PASS = 2'b00,
        XB_SWAP = 2'b01,
        XB_DUP0 = 2'b10,
        XB_DUP1 = 2'b11
    } xbar_mode_e;

    typedef enum logic [1:0] {
        HX_IDLE = 2'b00,
        HX_STAY = 2'b01,
        HX_MOVE = 2'b10,
        HX_BOTH = 2'b11
    } half_mode_e;

    localparam int ORN_CODE_W      = 2;
    localparam int ORN_OUT_DEPTH   = 2;

    function automatic int orn_latency(input int mcl);
        return mcl + 1 + ORN_OUT_DEPTH;
    endfunction

endpackage

// File: rtl/orn_half_cell.sv
module orn_half_cell
    import orn_pkg::*;
#(
    parameter int LANE_W = 65
) (
    input  logic [LANE_W-1:0]     lane_in,
    input  logic [ORN_CODE_W-1:0] mode,
    output logic [LANE_W-1:0]     out_stay,
    output logic [LANE_W-1:0]     out_move
);
    logic [LANE_W-1:0] gated;

    // a source with its valid bit low is an idle lane
    assign gated = lane_in[LANE_W-1] ? lane_in : '0;

    always_comb begin
        out_stay = '0;
        out_move = '0;
        case (half_mode_e'(mode))
            HX_IDLE: begin
                out_stay = '0;
                out_move = '0;
            end
            HX_STAY: out_stay = gated;
            HX_MOVE: out_move = gated;
            HX_BOTH: begin
                out_stay = gated;
                out_move = gated;
            end
            default: begin
                out_stay = '0;
                out_move = '0;
            end
        endcase
    end
endmodule

// File: rtl/orn_xbar_cell.sv
module orn_xbar_cell
    import orn_pkg::*;
#(
    parameter int LANE_W = 65
) (
    input  logic [LANE_W-1:0]     in0,
    input  logic [LANE_W-1:0]     in1,
    input  logic [ORN_CODE_W-1:0] mode,
    output logic [LANE_W-1:0]     out0,
    output logic [LANE_W-1:0]     out1
);
    always_comb begin
        out0 = in0;
        out1 = in1;
        case (xbar_mode_e'(mode))
            XB_PASS: begin
                out0 = in0;
                out1 = in1;
            end
            XB_SWAP: begin
                out0 = in1;
                out1 = in0;
            end
            XB_DUP0: begin
                out0 = in0;
                out1 = in0;
            end
            XB_DUP1: begin
                out0 = in1;
                out1 = in1;
            end
            default: begin
                out0 = in0;
                out1 = in1;
            end
        endcase
    end
endmodule

// File: rtl/orn_delay.sv
module orn_delay #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] pipe [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) pipe[i] <= '0;
        end else begin
            pipe[0] <= din;
            for (int i = 1; i < DEPTH; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign dout = pipe[DEPTH-1];
endmodule

// File: rtl/orn_port_fabric.sv
module orn_port_fabric
    import orn_pkg::*;
#(
    parameter int M      = 8,
    parameter int MCL    = 3,
    parameter int DATA_W = 64
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [M*(DATA_W+1)-1:0]     src_lane,
    input  logic [ORN_CODE_W*M-1:0]     cfg_half,
    input  logic [ORN_CODE_W*MCL*M-1:0] cfg_xbar,
    output logic [M*(DATA_W+1)-1:0]     out_lane
);
    localparam int LANE_W = DATA_W + 1;
    localparam int ROW_W  = M * LANE_W;
    localparam int MOVE_W = (M - 1) * LANE_W;

    genvar h, c;
    generate
        for (h = 0; h <= MCL; h++) begin : hop_g
            logic [ROW_W-1:0]  stay_d;
            logic [ROW_W-1:0]  move_d;
            logic [ROW_W-1:0]  stay_q;
            logic [MOVE_W-1:0] move_q;
            logic [LANE_W-1:0] spill_unused;

            // the move track leaving the rightmost column is dropped
            assign spill_unused = move_d[ROW_W-1 -: LANE_W];

            if (h == 0) begin : entry_g
                for (c = 0; c < M; c++) begin : col_g
                    orn_half_cell #(.LANE_W(LANE_W)) half_i (
                        .lane_in  (src_lane[c*LANE_W +: LANE_W]),
                        .mode     (cfg_half[c*ORN_CODE_W +: ORN_CODE_W]),
                        .out_stay (stay_d[c*LANE_W +: LANE_W]),
                        .out_move (move_d[c*LANE_W +: LANE_W])
                    );
                end
            end else begin : step_g
                for (c = 0; c < M; c++) begin : col_g
                    logic [LANE_W-1:0] arrive;
                    if (c == 0) begin : edge_g
                        assign arrive = '0;
                    end else begin : link_g
                        assign arrive = hop_g[h-1].move_q[(c-1)*LANE_W +: LANE_W];
                    end
                    orn_xbar_cell #(.LANE_W(LANE_W)) xbar_i (
                        .in0  (hop_g[h-1].stay_q[c*LANE_W +: LANE_W]),
                        .in1  (arrive),
                        .mode (cfg_xbar[((h-1)*M + c)*ORN_CODE_W +: ORN_CODE_W]),
                        .out0 (stay_d[c*LANE_W +: LANE_W]),
                        .out1 (move_d[c*LANE_W +: LANE_W])
                    );
                end
            end

            always_ff @(posedge clk) begin
                if (rst) begin
                    stay_q <= '0;
                    move_q <= '0;
                end else begin
                    stay_q <= stay_d;
                    move_q <= move_d[MOVE_W-1:0];
                end
            end

            if (h == MCL) begin : tail_g
                logic [MOVE_W-1:0] tail_unused;
                assign tail_unused = move_q;
            end
        end
    endgenerate

    orn_delay #(.WIDTH(ROW_W), .DEPTH(ORN_OUT_DEPTH)) out_dly_i (
        .clk  (clk),
        .rst  (rst),
        .din  (hop_g[MCL].stay_q),
        .dout (out_lane)
    );
endmodule

// File: rtl/orn_row.sv
module orn_row
    import orn_pkg::*;
#(
    parameter int M      = 8,
    parameter int MCL    = 3,
    parameter int DATA_W = 64
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [M-1:0]              src_valid,
    input  logic [M*DATA_W-1:0]       src_data,
    input  logic [2*ORN_CODE_W*M-1:0]     cfg_half,
    input  logic [2*ORN_CODE_W*MCL*M-1:0] cfg_xbar,
    output logic [M-1:0]              opa_valid,
    output logic [M*DATA_W-1:0]       opa_data,
    output logic [M-1:0]              opb_valid,
    output logic [M*DATA_W-1:0]       opb_data
);
    localparam int LANE_W    = DATA_W + 1;
    localparam int ROW_W     = M * LANE_W;
    localparam int HALF_CW   = ORN_CODE_W * M;
    localparam int XBAR_CW   = ORN_CODE_W * MCL * M;
    localparam int NUM_PORTS = 2;

    logic [ROW_W-1:0]           src_lane;
    logic [NUM_PORTS*ROW_W-1:0] port_lane;

    genvar j, p, k;
    generate
        for (j = 0; j < M; j++) begin : pack_g
            assign src_lane[j*LANE_W +: LANE_W] = {src_valid[j], src_data[j*DATA_W +: DATA_W]};
        end

        for (p = 0; p < NUM_PORTS; p++) begin : port_g
            orn_port_fabric #(.M(M), .MCL(MCL), .DATA_W(DATA_W)) fabric_i (
                .clk      (clk),
                .rst      (rst),
                .src_lane (src_lane),
                .cfg_half (cfg_half[p*HALF_CW +: HALF_CW]),
                .cfg_xbar (cfg_xbar[p*XBAR_CW +: XBAR_CW]),
                .out_lane (port_lane[p*ROW_W +: ROW_W])
            );
        end

        for (k = 0; k < M; k++) begin : unpack_g
            assign opa_valid[k]                = port_lane[k*LANE_W + DATA_W];
            assign opa_data[k*DATA_W +: DATA_W] = port_lane[k*LANE_W +: DATA_W];
            assign opb_valid[k]                = port_lane[ROW_W + k*LANE_W + DATA_W];
            assign opb_data[k*DATA_W +: DATA_W] = port_lane[ROW_W + k*LANE_W +: DATA_W];
        end
    endgenerate
endmodule

// File: rtl/orn_row_chk.sv
module orn_row_chk
    import orn_pkg::*;
#(
    parameter int M      = 8,
    parameter int MCL    = 3,
    parameter int DATA_W = 64
) (
    input logic                clk,
    input logic                rst,
    input logic [M-1:0]        src_valid,
    input logic [M-1:0]        opa_valid,
    input logic [M*DATA_W-1:0] opa_data,
    input logic [M-1:0]        opb_valid,
    input logic [M*DATA_W-1:0] opb_data
);
    localparam int LAT   = orn_latency(MCL);
    localparam int CNT_W = $clog2(LAT + 1) + 1;

    function automatic logic [M-1:0] win_mask(input int col);
        logic [M-1:0] m;
        for (int i = 0; i < M; i++) m[i] = (i <= col) && (i + MCL >= col);
        return m;
    endfunction

    logic [CNT_W-1:0] idle_cnt;
    logic [M-1:0]     hist [LAT];

    always_ff @(posedge clk) begin
        if (rst) begin
            idle_cnt <= '0;
            for (int i = 0; i < LAT; i++) hist[i] <= '0;
        end else begin
            if (|src_valid)                 idle_cnt <= '0;
            else if (idle_cnt < CNT_W'(LAT)) idle_cnt <= idle_cnt + 1'b1;
            hist[0] <= src_valid;
            for (int i = 1; i < LAT; i++) hist[i] <= hist[i-1];
        end
    end

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (opa_valid == '0 && opb_valid == '0 && opa_data == '0 && opb_data == '0)); // R1

    AST_DRAIN_IDLE: assert property (@(posedge clk) disable iff (rst)
        (idle_cnt >= CNT_W'(LAT)) |-> (opa_valid == '0 && opb_valid == '0)); // R9

    genvar k;
    generate
        for (k = 0; k < M; k++) begin : col_g
            localparam logic [M-1:0] WIN = win_mask(k);

            AST_IDLE_ZERO_A: assert property (@(posedge clk) disable iff (rst)
                !opa_valid[k] |-> (opa_data[k*DATA_W +: DATA_W] == '0)); // R7
            AST_IDLE_ZERO_B: assert property (@(posedge clk) disable iff (rst)
                !opb_valid[k] |-> (opb_data[k*DATA_W +: DATA_W] == '0)); // R7
            AST_REACH_WINDOW_A: assert property (@(posedge clk) disable iff (rst)
                opa_valid[k] |-> |(hist[LAT-1] & WIN)); // R6
            AST_REACH_WINDOW_B: assert property (@(posedge clk) disable iff (rst)
                opb_valid[k] |-> |(hist[LAT-1] & WIN)); // R6
        end
    endgenerate
endmodule

bind orn_row orn_row_chk #(.M(M), .MCL(MCL), .DATA_W(DATA_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .src_valid (src_valid),
    .opa_valid (opa_valid),
    .opa_data  (opa_data),
    .opb_valid (opb_valid),
    .opb_data  (opb_data)
);

// File: tb/orn_row_tb_top.sv
`timescale 1ns/1ps
module orn_row_tb_top;
    localparam int M    = 8;
    localparam int MCL  = 3;
    localparam int W    = 64;
    localparam int LW   = W + 1;
    localparam int LAT  = MCL + 3;
    localparam int RING = 64;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic                rst;
    logic [M-1:0]        src_valid;
    logic [M*W-1:0]      src_data;
    logic [4*M-1:0]      cfg_half;
    logic [4*MCL*M-1:0]  cfg_xbar;
    logic [M-1:0]        opa_valid, opb_valid;
    logic [M*W-1:0]      opa_data, opb_data;

    orn_row #(.M(M), .MCL(MCL), .DATA_W(W)) dut_i (
        .clk(clk), .rst(rst), .src_valid(src_valid), .src_data(src_data),
        .cfg_half(cfg_half), .cfg_xbar(cfg_xbar),
        .opa_valid(opa_valid), .opa_data(opa_data),
        .opb_valid(opb_valid), .opb_data(opb_data)
    );

    int total = 0;
    int bad   = 0;
    int k     = RING;
    bit done  = 0;

    logic [M-1:0]   ev_a [RING];
    logic [M-1:0]   ev_b [RING];
    logic [M*W-1:0] ed_a [RING];
    logic [M*W-1:0] ed_b [RING];
    string          et   [RING];

    // independent model of the routing rules R3..R5, R7
    task automatic model(output logic [M-1:0] va, output logic [M-1:0] vb,
                         output logic [M*W-1:0] da, output logic [M*W-1:0] db);
        logic [LW-1:0] st [M];
        logic [LW-1:0] mv [M];
        logic [LW-1:0] ns [M];
        logic [LW-1:0] nm [M];
        logic [LW-1:0] in0, in1, ln;
        logic [1:0]    cd;
        va = '0; vb = '0; da = '0; db = '0;
        for (int p = 0; p < 2; p++) begin
            for (int j = 0; j < M; j++) begin
                ln = src_valid[j] ? {1'b1, src_data[j*W +: W]} : '0;
                cd = cfg_half[2*(p*M+j) +: 2];
                st[j] = cd[0] ? ln : '0;
                mv[j] = cd[1] ? ln : '0;
            end
            for (int h = 1; h <= MCL; h++) begin
                for (int c = 0; c < M; c++) begin
                    in0 = st[c];
                    in1 = (c == 0) ? '0 : mv[c-1];
                    cd  = cfg_xbar[2*((p*MCL+h-1)*M+c) +: 2];
                    case (cd)
                        2'b00:   begin ns[c] = in0; nm[c] = in1; end
                        2'b01:   begin ns[c] = in1; nm[c] = in0; end
                        2'b10:   begin ns[c] = in0; nm[c] = in0; end
                        default: begin ns[c] = in1; nm[c] = in1; end
                    endcase
                end
                for (int c = 0; c < M; c++) begin
                    st[c] = ns[c];
                    mv[c] = nm[c];
                end
            end
            for (int c = 0; c < M; c++) begin
                if (p == 0) begin
                    va[c] = st[c][W];
                    da[c*W +: W] = st[c][W-1:0];
                end else begin
                    vb[c] = st[c][W];
                    db[c*W +: W] = st[c][W-1:0];
                end
            end
        end
    endtask

    task automatic check_ports(input string tag, input logic [M-1:0] va, input logic [M*W-1:0] da,
                               input logic [M-1:0] vb, input logic [M*W-1:0] db);
        total++;
        if (opa_valid !== va || opa_data !== da) begin
            bad++;
            $display("FAIL %s port A: actual valid=%h data=%h expected valid=%h data=%h",
                     tag, opa_valid, opa_data, va, da);
        end
        total++;
        if (opb_valid !== vb || opb_data !== db) begin
            bad++;
            $display("FAIL %s port B: actual valid=%h data=%h expected valid=%h data=%h",
                     tag, opb_valid, opb_data, vb, db);
        end
    endtask

    // inputs were set at the previous negedge; result appears LAT edges later (R2)
    task automatic step(input string tag);
        int idx;
        model(ev_a[k % RING], ev_b[k % RING], ed_a[k % RING], ed_b[k % RING]);
        et[k % RING] = tag;
        k++;
        @(negedge clk);
        idx = (k - LAT) % RING;
        check_ports(et[idx], ev_a[idx], ed_a[idx], ev_b[idx], ed_b[idx]);
    endtask

    task automatic clear_ring();
        for (int i = 0; i < RING; i++) begin
            ev_a[i] = '0; ev_b[i] = '0; ed_a[i] = '0; ed_b[i] = '0; et[i] = "R1";
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        src_valid = '0;
        src_data  = '0;
        @(negedge clk);
        rst = 1'b0;
        clear_ring();
        check_ports("R1", '0, '0, '0, '0);
    endtask

    task automatic rand_src();
        logic [31:0] r;
        r = $urandom;
        src_valid = r[M-1:0];
        for (int j = 0; j < M; j++) src_data[j*W +: W] = {$urandom, $urandom};
    endtask

    task automatic drain();
        for (int i = 0; i < LAT; i++) begin
            src_valid = '0;
            src_data  = '0;
            step("R9");
        end
    endtask

    task automatic half_all(input int p, input logic [1:0] code);
        for (int j = 0; j < M; j++) cfg_half[2*(p*M+j) +: 2] = code;
    endtask

    task automatic xb_set(input int p, input int h, input int c, input logic [1:0] code);
        cfg_xbar[2*((p*MCL+h-1)*M+c) +: 2] = code;
    endtask

    task automatic xb_hop(input int p, input int h, input logic [1:0] code);
        for (int c = 0; c < M; c++) xb_set(p, h, c, code);
    endtask

    task automatic xb_clear();
        cfg_xbar = '0;
    endtask

    initial begin
        logic [31:0] seed;
        seed = $urandom(32'h0C0FFEE1);
        rst = 1'b1;
        src_valid = '0;
        src_data  = '0;
        cfg_half  = '0;
        cfg_xbar  = '0;
        clear_ring();
        repeat (3) @(negedge clk);

        // R1: reset state
        do_reset();

        // R5/R2: straight routing on both ports, all sources live
        half_all(0, 2'b01); half_all(1, 2'b01); xb_clear();
        for (int i = 0; i < 10; i++) begin
            src_valid = '1;
            for (int j = 0; j < M; j++) src_data[j*W +: W] = {$urandom, $urandom};
            step("R5");
        end
        for (int i = 0; i < 10; i++) begin rand_src(); step("R2"); end
        drain();

        // R4: port A moved MCL columns then swapped into place; port B straight
        half_all(0, 2'b10); half_all(1, 2'b01); xb_clear();
        xb_hop(0, MCL, 2'b01);
        for (int i = 0; i < 12; i++) begin rand_src(); step("R4"); end
        drain();

        // R6: port B parks at hop d, giving an offset of exactly d
        for (int d = 1; d <= MCL; d++) begin
            half_all(0, 2'b01); half_all(1, 2'b10); xb_clear();
            xb_hop(1, d, 2'b01);
            for (int i = 0; i < 8; i++) begin rand_src(); step("R6"); end
            drain();
        end

        // R8: source 0 multicast to columns 0..MCL on A, and to B straight
        cfg_half = '0;
        cfg_half[1:0] = 2'b11;
        half_all(1, 2'b01);
        xb_clear();
        for (int h = 1; h <= MCL; h++) xb_set(0, h, h, 2'b11);
        for (int i = 0; i < 8; i++) begin rand_src(); src_valid[0] = 1'b1; step("R8"); end
        drain();

        // R7: invalid sources with nonzero data stay idle
        half_all(0, 2'b11); half_all(1, 2'b01); xb_clear();
        for (int i = 0; i < 6; i++) begin
            rand_src();
            src_valid = '0;
            step("R7");
        end
        drain();

        // R3/R5: move-only entry with no parking; everything falls off the edge
        half_all(0, 2'b10); half_all(1, 2'b00); xb_clear();
        for (int i = 0; i < 6; i++) begin rand_src(); step("R3"); end
        drain();

        // R4: duplicate-input-0 at hop 1 keeps the straight result
        half_all(0, 2'b01); half_all(1, 2'b11); xb_clear();
        xb_hop(0, 1, 2'b10);
        xb_hop(1, 1, 2'b10);
        for (int i = 0; i < 6; i++) begin rand_src(); step("R4"); end
        drain();

        // R4/R9: random configurations with random traffic
        for (int n = 0; n < 24; n++) begin
            cfg_half = $urandom;
            cfg_xbar = {$urandom, $urandom, $urandom};
            for (int i = 0; i < 16; i++) begin rand_src(); step("R4"); end
            drain();
        end

        // R1: reset in the middle of traffic
        half_all(0, 2'b01); half_all(1, 2'b01); xb_clear();
        for (int i = 0; i < 4; i++) begin
            src_valid = '1;
            for (int j = 0; j < M; j++) src_data[j*W +: W] = {$urandom, $urandom};
            step("R2");
        end
        do_reset();
        drain();

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R2 watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule